// File: doc/BRIEF.md
# Nibble-Field Register ALU

This block is the execution unit for a processor whose four 64-bit working registers are each split into sixteen 4-bit nibbles. An operation names a destination register, a source register, a field code and an opcode. The unit takes the chosen field from the destination register and from the source register and right-justifies each. It then computes a copy, add, subtract, multiply, divide, modulo, complement, negate, left shift, right shift or XOR on these 64-bit values. The result goes back into the same nibbles of the destination register. Nibbles outside the field keep their old values.

Some field codes depend on a nibble pointer, which comes in on its own input. The register file sits inside the block. It has a load port and a read port, so the surrounding pipeline can fill the registers and observe them. A one-cycle `start` pulse triggers an operation. One clock later the result is in the register file and `done` pulses, along with the illegal-opcode and divide-error flags.

Top module: `nibble_field_alu`

## Requirements
- R1: After synchronous reset, `done`, `illegal` and `div_err` are low and all four registers read as zero.
- R2: With `ld_en` high at a clock edge, register `ld_idx` takes `ld_data`. `rd_data` always shows register `rd_idx`.
- R3: Field code 0 is the single nibble at position `ptr`. Field code 1 is nibbles 0 through `ptr` inclusive, unshifted.
- R4: Field code 2 is nibble 2 (bits 11:8), code 3 is bits 11:0, code 4 is bits 63:60, code 5 is bits 59:12, code 6 is bits 7:0, code 7 is bits 63:0 and code 15 is bits 19:0. On read, each field is shifted down to bit 0.
- R5: Field codes 8 to 14 read and write all 64 bits.
- R6: `reg_sel[1:0]` picks both the destination and the first operand. `reg_sel[3:2]` picks the second operand.
- R7: Opcode 0x80 copies the second operand. Opcodes 0x81, 0x82 and 0x83 give the first plus the second, the first minus the second, and the low 64 bits of their product, all modulo 2^64.
- R8: Opcodes 0x84 and 0x85 give the unsigned quotient and remainder of the first operand by the second. A zero divisor writes all ones into the field and raises `div_err` with `done`.
- R9: Opcode 0x86 gives the bitwise complement of the second operand, and 0x87 gives its two's-complement negation.
- R10: Opcodes 0x88 and 0x89 shift the first operand left and right, logically, by the second operand. A shift amount of 64 or more gives zero.
- R11: Opcode 0x8A gives the XOR of the two operands.
- R12: The low nibbles of the 64-bit result fill the field, starting at its lowest nibble. Higher result nibbles are dropped, and nibbles outside the field are left unchanged.
- R13: Any opcode outside 0x80 to 0x8A raises `illegal` with `done` and leaves every register unchanged.
- R14: `done` is high in exactly the cycle after a `start` cycle. The written result shows on `rd_data` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Executes the operation on the inputs this cycle |
| opcode | input | 8 | Operation code, 0x80 to 0x8A |
| reg_sel | input | 4 | [1:0] destination/first operand, [3:2] second operand |
| field | input | 4 | Field code |
| ptr | input | 4 | Nibble pointer for field codes 0 and 1 |
| ld_en | input | 1 | Load enable for the register file |
| ld_idx | input | 2 | Register to load |
| ld_data | input | 64 | Load value |
| rd_idx | input | 2 | Register shown on rd_data |
| rd_data | output | 64 | Contents of register rd_idx |
| done | output | 1 | Operation completed |
| illegal | output | 1 | Unknown opcode, valid with done |
| div_err | output | 1 | Zero divisor, valid with done |

## Verification
The bench targets field edges:
- Pointer 15 with field code 0 and field code 1. A wrong pointer decode would write the wrong nibble or stop the mask early.
- Sums that overflow a narrow field. A design that did not truncate would carry into the neighbouring nibbles.
- The top nibble and the 48-bit middle field. Off-by-one shift counts would move the data.

It also drives:
- Zero divisors. A design that left the field alone or kept the flag low would be caught.
- Shifts of exactly 64 and more. A design that wrapped the shift count would return a nonzero value.
- Unknown opcodes. A design that wrote anyway would change a register.

All four registers are read back after every operation, so a write into the wrong register or into a neighbouring field is seen.

// File: rtl/nfalu_pkg.sv
package nfalu_pkg;

    localparam int NIB_W  = 4;
    localparam int NIBS   = 16;
    localparam int WORD_W = NIB_W * NIBS;
    localparam int NREGS  = 4;
    localparam int IDX_W  = $clog2(NREGS);
    localparam int POS_W  = $clog2(NIBS);
    localparam int LEN_W  = POS_W + 1;
    localparam int SH_W   = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [7:0] {
        OP_MOV = 8'h80,
        OP_ADD = 8'h81,
        OP_SUB = 8'h82,
        OP_MUL = 8'h83,
        OP_DIV = 8'h84,
        OP_MOD = 8'h85,
        OP_NOT = 8'h86,
        OP_NEG = 8'h87,
        OP_SHL = 8'h88,
        OP_SHR = 8'h89,
        OP_XOR = 8'h8A
    } op_e;

    localparam logic [3:0] FLD_AT_P  = 4'd0;
    localparam logic [3:0] FLD_TO_P  = 4'd1;
    localparam logic [3:0] FLD_NIB2  = 4'd2;
    localparam logic [3:0] FLD_LOW3  = 4'd3;
    localparam logic [3:0] FLD_TOP   = 4'd4;
    localparam logic [3:0] FLD_MID   = 4'd5;
    localparam logic [3:0] FLD_BYTE  = 4'd6;
    localparam logic [3:0] FLD_WORD  = 4'd7;
    localparam logic [3:0] FLD_LOW5  = 4'd15;

    // nibble span: lowest nibble and number of nibbles
    typedef struct packed {
        logic [POS_W-1:0] lsb;
        logic [LEN_W-1:0] len;
    } span_t;

    function automatic span_t decode_span(logic [3:0] code, logic [POS_W-1:0] p);
        span_t s;
        s.lsb = '0;
        s.len = LEN_W'(NIBS);
        case (code)
            FLD_AT_P: begin s.lsb = p;            s.len = LEN_W'(1);  end
            FLD_TO_P: begin s.lsb = '0;           s.len = LEN_W'(p) + LEN_W'(1); end
            FLD_NIB2: begin s.lsb = POS_W'(2);    s.len = LEN_W'(1);  end
            FLD_LOW3: begin s.lsb = '0;           s.len = LEN_W'(3);  end
            FLD_TOP:  begin s.lsb = POS_W'(NIBS-1); s.len = LEN_W'(1); end
            FLD_MID:  begin s.lsb = POS_W'(3);    s.len = LEN_W'(12); end
            FLD_BYTE: begin s.lsb = '0;           s.len = LEN_W'(2);  end
            FLD_WORD: begin s.lsb = '0;           s.len = LEN_W'(NIBS); end
            FLD_LOW5: begin s.lsb = '0;           s.len = LEN_W'(5);  end
            default:  begin s.lsb = '0;           s.len = LEN_W'(NIBS); end
        endcase
        return s;
    endfunction

    function automatic word_t nib_mask(int lo, int len);
        word_t m;
        m = '0;
        for (int i = 0; i < NIBS; i++) begin
            if (i >= lo && i < lo + len)
                m[i*NIB_W +: NIB_W] = {NIB_W{1'b1}};
        end
        return m;
    endfunction

    function automatic word_t span_mask(span_t s);
        return nib_mask(int'(s.lsb), int'(s.len));
    endfunction

    function automatic word_t low_mask(span_t s);
        return nib_mask(0, int'(s.len));
    endfunction

endpackage

// File: rtl/nfalu_regfile.sv
module nfalu_regfile
    import nfalu_pkg::*;
#(
    parameter int N = NREGS,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_we,
    input  logic [IW-1:0] op_idx,
    input  word_t         op_data,
    input  logic          ld_we,
    input  logic [IW-1:0] ld_idx,
    input  word_t         ld_data,
    input  logic [IW-1:0] ra_idx,
    input  logic [IW-1:0] rb_idx,
    input  logic [IW-1:0] rd_idx,
    output word_t         ra_q,
    output word_t         rb_q,
    output word_t         rd_q
);

    word_t [N-1:0] regs_q;

    // the operation write port wins over the load port on the same register
    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (op_we && int'(op_idx) == i)
                    regs_q[i] <= op_data;
                else if (ld_we && int'(ld_idx) == i)
                    regs_q[i] <= ld_data;
            end
        end
    end

    assign ra_q = regs_q[ra_idx];
    assign rb_q = regs_q[rb_idx];
    assign rd_q = regs_q[rd_idx];

    // R2
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_we && !(op_we && op_idx == ld_idx)) |=> regs_q[$past(ld_idx)] == $past(ld_data));

endmodule

// File: rtl/nfalu_extract.sv
module nfalu_extract
    import nfalu_pkg::*;
(
    input  word_t word,
    input  span_t span,
    output word_t value
);

    assign value = (word >> (NIB_W * int'(span.lsb))) & low_mask(span);

endmodule

// File: rtl/nfalu_merge.sv
module nfalu_merge
    import nfalu_pkg::*;
(
    input  word_t old_word,
    input  word_t result,
    input  span_t span,
    output word_t merged
);

    word_t keep_m;
    word_t placed;

    assign keep_m = span_mask(span);
    assign placed = result << (NIB_W * int'(span.lsb));
    assign merged = (old_word & ~keep_m) | (placed & keep_m);

endmodule

// File: rtl/nfalu_core.sv
module nfalu_core
    import nfalu_pkg::*;
(
    input  logic [7:0] op_code,
    input  word_t      a,
    input  word_t      b,
    output word_t      result,
    output logic       legal,
    output logic       dz
);

    always_comb begin
        result = '0;
        legal  = 1'b1;
        dz     = 1'b0;
        case (op_code)
            OP_MOV: result = b;
            OP_ADD: result = a + b;
            OP_SUB: result = a - b;
            OP_MUL: result = a * b;
            OP_DIV: begin
                if (b == '0) begin
                    result = '1;
                    dz     = 1'b1;
                end else begin
                    result = a / b;
                end
            end
            OP_MOD: begin
                if (b == '0) begin
                    result = '1;
                    dz     = 1'b1;
                end else begin
                    result = a % b;
                end
            end
            OP_NOT: result = ~b;
            OP_NEG: result = '0 - b;
            OP_SHL: result = (b >= word_t'(WORD_W)) ? '0 : (a << b[SH_W-1:0]);
            OP_SHR: result = (b >= word_t'(WORD_W)) ? '0 : (a >> b[SH_W-1:0]);
            OP_XOR: result = a ^ b;
            default: legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/nibble_field_alu.sv
module nibble_field_alu
    import nfalu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [7:0]           opcode,
    input  logic [2*IDX_W-1:0]   reg_sel,
    input  logic [3:0]           field,
    input  logic [POS_W-1:0]     ptr,
    input  logic                 ld_en,
    input  logic [IDX_W-1:0]     ld_idx,
    input  logic [WORD_W-1:0]    ld_data,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [WORD_W-1:0]    rd_data,
    output logic                 done,
    output logic                 illegal,
    output logic                 div_err
);

    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] src;
    span_t            span;
    word_t            dst_word, src_word;
    word_t            opnd [2];
    word_t            res, merged;
    logic             legal, dz;

    assign dst  = reg_sel[IDX_W-1:0];
    assign src  = reg_sel[2*IDX_W-1:IDX_W];
    assign span = decode_span(field, ptr);

    nfalu_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .op_we   (start && legal),
        .op_idx  (dst),
        .op_data (merged),
        .ld_we   (ld_en),
        .ld_idx  (ld_idx),
        .ld_data (ld_data),
        .ra_idx  (dst),
        .rb_idx  (src),
        .rd_idx  (rd_idx),
        .ra_q    (dst_word),
        .rb_q    (src_word),
        .rd_q    (rd_data)
    );

    word_t raw [2];
    assign raw[0] = dst_word;
    assign raw[1] = src_word;

    for (genvar g = 0; g < 2; g++) begin : g_ext
        nfalu_extract u_ext (
            .word  (raw[g]),
            .span  (span),
            .value (opnd[g])
        );
    end

    nfalu_core u_core (
        .op_code (opcode),
        .a       (opnd[0]),
        .b       (opnd[1]),
        .result  (res),
        .legal   (legal),
        .dz      (dz)
    );

    nfalu_merge u_merge (
        .old_word (dst_word),
        .result   (res),
        .span     (span),
        .merged   (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            illegal <= 1'b0;
            div_err <= 1'b0;
        end else begin
            done    <= start;
            illegal <= start && !legal;
            div_err <= start && legal && dz;
        end
    end

    // R14
    done_follow_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    // R13
    illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !legal && !ld_en) |=> $stable(u_rf.regs_q));

    // R12
    outside_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (start && legal && !ld_en) |=>
            ((u_rf.regs_q[$past(dst)] ^ $past(dst_word)) & ~$past(span_mask(span))) == '0);

    // R8
    div_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (start && dz) |-> (opnd[1] == '0 && res == '1 &&
                           (opcode == OP_DIV || opcode == OP_MOD)));

    // R10
    shift_wide_chk: assert property (@(posedge clk) disable iff (rst)
        (start && (opcode == OP_SHL || opcode == OP_SHR) && opnd[1] >= word_t'(WORD_W))
            |-> res == '0);

endmodule

// File: tb/nibble_field_alu_test.sv
`timescale 1ns/10ps
module nibble_field_alu_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h80;
    logic [3:0]  reg_sel = '0;
    logic [3:0]  field = '0;
    logic [3:0]  ptr = '0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_idx = '0;
    logic [63:0] ld_data = '0;
    logic [1:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic        done, illegal, div_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [63:0] model [4];

    always #4 clk = ~clk;

    nibble_field_alu uut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .reg_sel(reg_sel),
        .field(field), .ptr(ptr), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .done(done), .illegal(illegal),
        .div_err(div_err)
    );

    function automatic int f_lo(int code, int p);
        case (code)
            0: return p;
            2: return 2;
            4: return 15;
            5: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic int f_len(int code, int p);
        case (code)
            0: return 1;
            1: return p + 1;
            2: return 1;
            3: return 3;
            4: return 1;
            5: return 12;
            6: return 2;
            15: return 5;
            default: return 16;
        endcase
    endfunction

    function automatic logic [63:0] lmask(int n);
        if (n >= 16) return '1;
        return (64'd1 << (4*n)) - 64'd1;
    endfunction

    function automatic logic [63:0] get_f(logic [63:0] w, int code, int p);
        return (w >> (4*f_lo(code, p))) & lmask(f_len(code, p));
    endfunction

    function automatic logic [63:0] put_f(logic [63:0] old, logic [63:0] v, int code, int p);
        logic [63:0] m;
        m = lmask(f_len(code, p)) << (4*f_lo(code, p));
        return (old & ~m) | ((v << (4*f_lo(code, p))) & m);
    endfunction

    function automatic logic [63:0] calc(logic [7:0] op, logic [63:0] a, logic [63:0] b,
                                         output bit ok, output bit dz);
        ok = 1; dz = 0;
        case (op)
            8'h80: return b;
            8'h81: return a + b;
            8'h82: return a - b;
            8'h83: return a * b;
            8'h84: begin if (b == 0) begin dz = 1; return '1; end return a / b; end
            8'h85: begin if (b == 0) begin dz = 1; return '1; end return a % b; end
            8'h86: return ~b;
            8'h87: return 64'd0 - b;
            8'h88: return (b > 63) ? 64'd0 : a << b;
            8'h89: return (b > 63) ? 64'd0 : a >> b;
            8'h8A: return a ^ b;
            default: begin ok = 0; return 64'd0; end
        endcase
    endfunction

    function automatic string tag_of(logic [7:0] op);
        if (op >= 8'h80 && op <= 8'h83) return "R7";
        if (op == 8'h84 || op == 8'h85) return "R8";
        if (op == 8'h86 || op == 8'h87) return "R9";
        if (op == 8'h88 || op == 8'h89) return "R10";
        if (op == 8'h8A) return "R11";
        return "R13";
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_regs(string req);
        for (int i = 0; i < 4; i++) begin
            rd_idx = 2'(i);
            #0.5;
            check(req, rd_data, model[i]);
        end
    endtask

    task automatic load(int idx, logic [63:0] d);
        @(negedge clk);
        ld_en = 1; ld_idx = 2'(idx); ld_data = d;
        @(negedge clk);
        ld_en = 0;
        model[idx] = d;
    endtask

    task automatic run_op(logic [7:0] op, int dst, int src, int code, int p, string req);
        logic [63:0] a, b, r;
        bit ok, dz;
        a = get_f(model[dst], code, p);
        b = get_f(model[src], code, p);
        r = calc(op, a, b, ok, dz);
        @(negedge clk);
        start = 1; opcode = op; reg_sel = {2'(src), 2'(dst)};
        field = 4'(code); ptr = 4'(p);
        @(negedge clk);
        start = 0;
        if (ok) model[dst] = put_f(model[dst], r, code, p);
        check({req, " R14 done"}, {63'd0, done}, 64'd1);
        check({req, " R13 illegal"}, {63'd0, illegal}, {63'd0, !ok});
        check({req, " R8 div_err"}, {63'd0, div_err}, {63'd0, dz});
        check_regs(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rop;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 done", {63'd0, done}, 0);
        check("R1 illegal", {63'd0, illegal}, 0);
        check("R1 div_err", {63'd0, div_err}, 0);
        check_regs("R1 regs");

        // R2 load and read back
        load(0, 64'h0123_4567_89AB_CDEF);
        load(1, 64'hFEDC_BA98_7654_3210);
        load(2, 64'hFFFF_FFFF_FFFF_FFFF);
        load(3, 64'h0000_0000_0000_0001);
        check_regs("R2");

        // R3 pointer-relative fields at the top pointer value
        run_op(8'h81, 0, 1, 0, 15, "R3 at_p");
        run_op(8'h80, 2, 0, 1, 3, "R3 to_p");
        run_op(8'h81, 1, 2, 1, 15, "R3 to_p full");
        // R4 fixed fields, R12 truncation into narrow fields
        run_op(8'h81, 2, 2, 2, 0, "R4 R12 nib2 carry");
        run_op(8'h80, 0, 1, 4, 0, "R4 top");
        run_op(8'h81, 1, 0, 5, 0, "R4 mid");
        run_op(8'h82, 3, 0, 15, 0, "R4 R12 low5 borrow");
        run_op(8'h83, 0, 2, 6, 0, "R4 byte");
        run_op(8'h87, 1, 3, 3, 0, "R4 low3");
        // R5 user-field codes act on the whole word
        run_op(8'h8A, 0, 1, 10, 0, "R5 code10");
        run_op(8'h81, 2, 3, 14, 0, "R5 code14");
        // R6 operand selection
        run_op(8'h82, 2, 1, 7, 0, "R6 sel");
        // R8 zero divisor
        load(3, 64'h0);
        run_op(8'h84, 0, 3, 7, 0, "R8 div0");
        run_op(8'h85, 1, 3, 3, 0, "R8 mod0");
        // R10 shifts of 64 and beyond
        load(3, 64'd64);
        run_op(8'h88, 0, 3, 7, 0, "R10 shl64");
        load(3, 64'd70);
        run_op(8'h89, 1, 3, 7, 0, "R10 shr70");
        load(3, 64'd63);
        load(2, 64'h8000_0000_0000_0001);
        run_op(8'h89, 2, 3, 7, 0, "R10 shr63");
        // R13 unknown opcodes
        run_op(8'h8B, 0, 1, 7, 0, "R13 8B");
        run_op(8'h00, 1, 0, 7, 0, "R13 00");
        // R14 done falls after one cycle
        @(negedge clk);
        check("R14 done low", {63'd0, done}, 0);

        for (int n = 0; n < 400; n++) begin
            if (n % 40 == 0) begin
                for (int k = 0; k < 4; k++)
                    load(k, {$urandom, $urandom});
            end
            if ($urandom % 16 == 0)
                rop = ($urandom % 2) ? 8'($urandom % 128) : 8'(8'h8B + $urandom % 116);
            else
                rop = 8'(8'h80 + $urandom % 11);
            run_op(rop, int'($urandom % 4), int'($urandom % 4), int'($urandom % 16),
                   int'($urandom % 16), tag_of(rop));
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule